// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the digital face of a multi-channel, simultaneous-sampling analog-to-digital converter. A host sees one shared 16-bit data bus plus active-low chip select, write, read and convert-start strobes, and an active-low end-of-conversion flag. The host uses the bus in two ways. It writes a 4-bit setup word that chooses the reference source, the result format and the acquisition mode. It also reads the per-channel results of the last conversion, one channel per read strobe. The tri-state pad sits outside the block, so the bus appears here as an input half, an output half and an output enable.

The analog core is replaced by a behavioural stand-in. The stand-in runs for a fixed number of clock cycles after each conversion start and then offers one raw unsigned code per channel. The interface latches those codes, pulls the end-of-conversion flag low, and presents the codes in the chosen format. All strobes are sampled on the system clock, and their edges are detected against the value from the previous cycle.

Top module: `adcif_bus_top`

## Requirements
- R1: After reset, `eoc_n` is 1, `dq_oe` is 0 and `ref_ext` is 0. Results are shown as offset binary, and acquisition follows the convert-start level.
- R2: In a cycle where `wr_n` is seen rising while `cs_n` is low, `dq_i[3]` sets the reference select, `dq_i[2]` sets the format and `dq_i[0]` sets the mode. `ref_ext` shows the new reference bit one cycle later. A `wr_n` rise while `cs_n` is high changes nothing.
- R3: Setup bit `dq_i[1]` is reserved. It is always stored as 0 and has no effect on the output.
- R4: `dq_oe` is 1 exactly when `cs_n` and `rd_n` are both low.
- R5: With format bit 0 the bus shows the raw code unchanged (offset binary). With format bit 1 it shows the raw code with bit 15 inverted (two's complement).
- R6: In mode 0 (`dq_i[0]`=0), a low `cnvst_n` starts acquisition and its next rise starts a conversion. A rise seen in the first cycle after a conversion ends is ignored, because acquisition has not yet begun in that cycle.
- R7: In mode 1, acquisition resumes right after a conversion ends, so a `cnvst_n` rise in the first following cycle starts a new conversion.
- R8: `eoc_n` goes low CONV_CYC cycles after the cycle in which the start rise is sampled. It goes high on the next read falling edge with `cs_n` low, or at the next conversion start. If a read falling edge lands on the completion cycle, the completion wins and `eoc_n` stays low.
- R9: Each `rd_n` falling edge with `cs_n` low presents the next channel in ascending order, starting from channel 0 after every conversion start and wrapping from NCH-1 back to 0. The presented value stays on the bus while the read strobe stays low.
- R10: A `cnvst_n` rise during a conversion is ignored. The completion time and the result set are unchanged.
- R11: A setup write during a conversion is accepted. The format of that conversion's results is the one in force when it started, and the new format applies from the next conversion onward.
- R12: For conversion number n since reset (counting from 0), the stand-in's raw code for channel c is (n*0x1357 + c*0x0F0F + 0x7F00) mod 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Setup write strobe; captures on its rising edge |
| rd_n | input | 1 | Result read strobe, active low |
| cnvst_n | input | 1 | Convert start; rising edge starts a conversion |
| dq_i | input | 16 | Bus value driven by the host (setup word in bits 3:0) |
| dq_o | output | 16 | Result value driven toward the bus pad |
| dq_oe | output | 1 | Pad output enable for `dq_o` |
| eoc_n | output | 1 | End of conversion, active low |
| ref_ext | output | 1 | Reference select: 0 internal, 1 external |

## Verification
The sharpest collision is a read falling edge that arrives in the same cycle as conversion completion. At that edge the flag set and flag clear meet, and so do the pointer advance and the new result latch. The bench lowers the read strobe CONV_CYC cycles after the start rise so that both events meet on one edge. It then expects `eoc_n` to stay low and the bus to show the new channel 0 code. The following read must show channel 1 and clear the flag. A cycle-by-cycle behavioural model in the bench judges every other cycle of the run as well.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int SAMPLE_W = 16;
    localparam int CFG_W    = 4;
    localparam int MSB      = SAMPLE_W - 1;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        CV_IDLE = 2'd0,
        CV_ACQ  = 2'd1,
        CV_CONV = 2'd2
    } conv_state_e;

    // Bit order follows the setup word on the bus: [3] ref, [2] fmt, [1] rsvd, [0] mode
    typedef struct packed {
        logic ref_ext;
        logic twos;
        logic rsvd;
        logic auto_acq;
    } cfg_t;

    // Offset binary to two's complement is a flip of the sign position
    function automatic sample_t present_code(input sample_t raw, input logic twos);
        sample_t r;
        r = raw;
        if (twos) begin
            r[MSB] = ~raw[MSB];
        end
        return r;
    endfunction

    // Deterministic code pattern of the behavioural converter stand-in
    function automatic sample_t stub_code(input sample_t n, input int unsigned c);
        logic [31:0] t;
        t = 32'(n) * 32'h1357 + 32'(c) * 32'h0F0F + 32'h7F00;
        return t[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/adcif_cfg_reg.sv
module adcif_cfg_reg
    import adcif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [CFG_W-1:0] cfg_d,
    output cfg_t             cfg_q
);

    logic wr_n_q;
    logic capture;

    assign capture = !cs_n && wr_n && !wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q <= 1'b1;
            cfg_q  <= '0;
        end else begin
            wr_n_q <= wr_n;
            if (capture) begin
                cfg_q.ref_ext  <= cfg_d[3];
                cfg_q.twos     <= cfg_d[2];
                cfg_q.rsvd     <= 1'b0;
                cfg_q.auto_acq <= cfg_d[0];
            end
        end
    end

    // R2: the setup word only ever changes right after a selected write rise
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> ($past(!cs_n) && $past(wr_n) && !$past(wr_n_q)));

endmodule

// File: rtl/adcif_conv_ctrl.sv
module adcif_conv_ctrl
    import adcif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cnvst_n,
    input  logic        auto_acq,
    input  logic        conv_done,
    input  logic        rd_fall,
    output logic        conv_start,
    output logic        eoc_n,
    output conv_state_e state_o
);

    conv_state_e state_q, state_d;
    logic        cnv_q;
    logic        cnv_rise;
    logic        eoc_q;

    assign cnv_rise   = cnvst_n && !cnv_q;
    assign conv_start = (state_q == CV_ACQ) && cnv_rise;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CV_IDLE: if (auto_acq || !cnvst_n) state_d = CV_ACQ;
            CV_ACQ:  if (cnv_rise)             state_d = CV_CONV;
            CV_CONV: if (conv_done)            state_d = auto_acq ? CV_ACQ : CV_IDLE;
            default:                           state_d = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CV_IDLE;
            cnv_q   <= 1'b1;
            eoc_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnv_q   <= cnvst_n;
            if (conv_done) begin
                eoc_q <= 1'b0;
            end else if (conv_start || rd_fall) begin
                eoc_q <= 1'b1;
            end
        end
    end

    assign eoc_n   = eoc_q;
    assign state_o = state_q;

endmodule

// File: rtl/adcif_conv_model.sv
module adcif_conv_model
    import adcif_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int CONV_CYC = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    output logic                           busy,
    output logic                           done,
    output logic [NCH-1:0][SAMPLE_W-1:0]   codes
);

    localparam int CW = $clog2(CONV_CYC + 1);

    logic [CW-1:0] cnt_q;
    sample_t       idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            idx_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CW'(CONV_CYC - 1);
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy  <= 1'b0;
                idx_q <= idx_q + 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign done = busy && (cnt_q == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign codes[g] = stub_code(idx_q, g);
    end

endmodule

// File: rtl/adcif_read_port.sv
module adcif_read_port
    import adcif_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n,
    input  logic                         rd_n,
    input  logic                         conv_start,
    input  logic                         conv_done,
    input  logic                         twos_cfg,
    input  logic [NCH-1:0][SAMPLE_W-1:0] codes,
    output sample_t                      dq_o,
    output logic                         dq_oe,
    output logic                         rd_fall
);

    localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [PW-1:0] LAST = PW'(NCH - 1);

    logic                         rd_n_q;
    logic [PW-1:0]                ptr_q, hold_q, out_idx;
    logic [NCH-1:0][SAMPLE_W-1:0] res_q;
    logic                         fmt_pend_q, fmt_res_q;

    assign rd_fall = !cs_n && !rd_n && rd_n_q;
    assign dq_oe   = !cs_n && !rd_n;
    assign out_idx = rd_fall ? ptr_q : hold_q;
    assign dq_o    = present_code(res_q[out_idx], fmt_res_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_n_q     <= 1'b1;
            ptr_q      <= '0;
            hold_q     <= '0;
            res_q      <= '0;
            fmt_pend_q <= 1'b0;
            fmt_res_q  <= 1'b0;
        end else begin
            rd_n_q <= rd_n;
            if (rd_fall) begin
                hold_q <= ptr_q;
                ptr_q  <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end
            if (conv_start) begin
                ptr_q      <= '0;
                fmt_pend_q <= twos_cfg;
            end
            if (conv_done) begin
                res_q     <= codes;
                fmt_res_q <= fmt_pend_q;
            end
        end
    end

endmodule

// File: rtl/adcif_bus_top.sv
module adcif_bus_top
    import adcif_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int CONV_CYC = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic                cnvst_n,
    input  logic [SAMPLE_W-1:0] dq_i,
    output logic [SAMPLE_W-1:0] dq_o,
    output logic                dq_oe,
    output logic                eoc_n,
    output logic                ref_ext
);

    cfg_t                         cfg;
    conv_state_e                  state;
    logic                         conv_start, conv_done, model_busy, rd_fall;
    logic [NCH-1:0][SAMPLE_W-1:0] codes;
    logic                         bus_hi_unused;

    assign bus_hi_unused = ^dq_i[SAMPLE_W-1:CFG_W];

    adcif_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .wr_n  (wr_n),
        .cfg_d (dq_i[CFG_W-1:0]),
        .cfg_q (cfg)
    );

    adcif_conv_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cnvst_n    (cnvst_n),
        .auto_acq   (cfg.auto_acq),
        .conv_done  (conv_done),
        .rd_fall    (rd_fall),
        .conv_start (conv_start),
        .eoc_n      (eoc_n),
        .state_o    (state)
    );

    adcif_conv_model #(.NCH(NCH), .CONV_CYC(CONV_CYC)) u_model (
        .clk   (clk),
        .rst   (rst),
        .start (conv_start),
        .busy  (model_busy),
        .done  (conv_done),
        .codes (codes)
    );

    adcif_read_port #(.NCH(NCH)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .twos_cfg   (cfg.twos),
        .codes      (codes),
        .dq_o       (dq_o),
        .dq_oe      (dq_oe),
        .rd_fall    (rd_fall)
    );

    assign ref_ext = cfg.ref_ext;

    // R8: completion only comes from a conversion in progress
    p_done_in_conv_r8: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> (state == CV_CONV));

    // R8: the flag falls only after the stand-in finished
    p_eoc_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc_n) |-> $past(conv_done));

    // R8: the flag rises only after a read edge or a new start
    p_eoc_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_n) |-> ($past(rd_fall) || $past(conv_start)));

    // R10: a start never reaches the stand-in while it is still converting
    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !model_busy);

    // R3: the reserved position of the stored setup word is never set
    p_rsvd_r3: assert property (@(posedge clk) disable iff (rst)
        $changed(cfg) |-> !cfg.rsvd);

endmodule

// File: tb/adcif_bus_top_test.sv
module adcif_bus_top_test;

    localparam int NCH = 8;
    localparam int CC  = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cnvst_n = 1'b1;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic        dq_oe, eoc_n, ref_ext;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done_run = 0;

    adcif_bus_top #(.NCH(NCH), .CONV_CYC(CC)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cnvst_n(cnvst_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .eoc_n(eoc_n), .ref_ext(ref_ext)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] raw(input int n, input int c);
        return 16'((n * 32'h1357 + c * 32'h0F0F + 32'h7F00) & 32'hFFFF);
    endfunction

    function automatic logic [15:0] shown(input logic [15:0] v, input bit twos);
        return twos ? (v ^ 16'h8000) : v;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference, one step per clock ----------------
    bit m_ref, m_twos, m_auto, m_eoc, m_busy, m_fpend, m_fres;
    bit p_wr, p_rd, p_cnv;
    int m_st, m_cnt, m_idx, m_ptr, m_hold;
    int m_res[NCH];

    always @(posedge clk) begin
        if (rst) begin
            m_ref = 0; m_twos = 0; m_auto = 0; m_eoc = 1; m_busy = 0;
            m_fpend = 0; m_fres = 0; p_wr = 1; p_rd = 1; p_cnv = 1;
            m_st = 0; m_cnt = 0; m_idx = 0; m_ptr = 0; m_hold = 0;
            foreach (m_res[i]) m_res[i] = 0;
        end else begin
            bit rise, wrise, rfall, fin, go;
            rise  = cnvst_n && !p_cnv;
            wrise = wr_n && !p_wr && !cs_n;
            rfall = !cs_n && !rd_n && p_rd;
            fin   = m_busy && (m_cnt == 0);
            go    = (m_st == 1) && rise;
            if (fin) m_eoc = 0;
            else if (go || rfall) m_eoc = 1;
            if (rfall) begin m_hold = m_ptr; m_ptr = (m_ptr + 1) % NCH; end
            if (go) begin m_ptr = 0; m_fpend = m_twos; end
            if (fin) begin
                for (int c = 0; c < NCH; c++) m_res[c] = int'(raw(m_idx, c));
                m_fres = m_fpend;
            end
            if (go) begin m_busy = 1; m_cnt = CC - 1; end
            else if (m_busy) begin
                if (m_cnt == 0) begin m_busy = 0; m_idx++; end
                else m_cnt--;
            end
            case (m_st)
                0: if (m_auto || !cnvst_n) m_st = 1;
                1: if (rise) m_st = 2;
                default: if (fin) m_st = m_auto ? 1 : 0;
            endcase
            if (wrise) begin m_ref = dq_i[3]; m_twos = dq_i[2]; m_auto = dq_i[0]; end
            p_wr = wr_n; p_rd = rd_n; p_cnv = cnvst_n;
        end
        #1;
        if (!rst && !done_run) begin
            int sel;
            sel = (!cs_n && !rd_n && p_rd) ? m_ptr : m_hold;
            check("R8 eoc_n", {15'd0, eoc_n}, {15'd0, m_eoc});
            check("R4 dq_oe", {15'd0, dq_oe}, {15'd0, !cs_n && !rd_n});
            check("R2 ref_ext", {15'd0, ref_ext}, {15'd0, m_ref});
            if (dq_oe) check("R9 dq_o", dq_o, shown(16'(m_res[sel]), m_fres));
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done_run) begin
            done_run = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // ---------------- host tasks ----------------
    task automatic wr_cfg(input logic [3:0] d, input bit sel);
        @(negedge clk); cs_n = !sel; wr_n = 0; dq_i = {12'h000, d};
        @(negedge clk); wr_n = 1;
        @(negedge clk); cs_n = 1; dq_i = '0;
    endtask

    task automatic rd_one(output logic [15:0] v);
        @(negedge clk); cs_n = 0; rd_n = 0;
        @(posedge clk); #1; v = dq_o;
        @(negedge clk); cs_n = 1; rd_n = 1;
    endtask

    task automatic start_conv();
        @(negedge clk); cnvst_n = 0;
        @(negedge clk); cnvst_n = 1;
    endtask

    task automatic wait_eoc(output int n);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (eoc_n && n < 1000);
    endtask

    initial begin
        logic [15:0] v;
        int n;
        bit stayed;
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        check("R1 eoc_n after reset", {15'd0, eoc_n}, 16'd1);
        check("R1 dq_oe after reset", {15'd0, dq_oe}, 16'd0);
        check("R1 ref_ext after reset", {15'd0, ref_ext}, 16'd0);

        // conversion 0, default setup: offset binary, ascending order, wrap
        start_conv(); wait_eoc(n);
        check("R8 completion latency", 16'(n), 16'(CC + 1));
        for (int c = 0; c < NCH; c++) begin
            rd_one(v);
            check("R12 R1 R5 raw code in offset binary", v, raw(0, c));
        end
        rd_one(v); check("R9 pointer wrap", v, raw(0, 0));

        // setup write with and without select
        wr_cfg(4'b1000, 0); @(posedge clk); #1;
        check("R2 unselected write ignored", {15'd0, ref_ext}, 16'd0);
        wr_cfg(4'b1000, 1); @(posedge clk); #1;
        check("R2 selected write", {15'd0, ref_ext}, 16'd1);

        // conversion 1: reserved bit set has no effect on format
        wr_cfg(4'b0010, 1);
        start_conv(); wait_eoc(n);
        rd_one(v); check("R3 reserved bit ignored", v, raw(1, 0));

        // conversion 2: two's complement
        wr_cfg(4'b0100, 1);
        start_conv(); wait_eoc(n);
        rd_one(v); check("R5 twos ch0", v, raw(2, 0) ^ 16'h8000);
        rd_one(v); check("R5 twos ch1", v, raw(2, 1) ^ 16'h8000);

        // conversions 3 and 4: setup write while converting
        start_conv(); wr_cfg(4'b0000, 1); wait_eoc(n);
        rd_one(v); check("R11 old format kept", v, raw(3, 0) ^ 16'h8000);
        start_conv(); wait_eoc(n);
        rd_one(v); check("R11 new format applied", v, raw(4, 0));

        // conversion 5: start rise during conversion ignored
        start_conv();
        @(negedge clk); @(negedge clk); cnvst_n = 0;
        @(negedge clk); cnvst_n = 1;
        wait_eoc(n);
        check("R10 latency unchanged", 16'(n), 16'(CC - 2));
        rd_one(v); check("R10 single result set", v, raw(5, 0));

        // conversion 6: mode 0 ignores a rise right after completion
        start_conv(); @(negedge clk); cnvst_n = 0;
        wait_eoc(n);
        @(negedge clk); cnvst_n = 1;
        stayed = 1;
        repeat (4) begin @(posedge clk); #1; if (eoc_n) stayed = 0; end
        check("R6 rise after completion ignored", {15'd0, stayed}, 16'd1);
        rd_one(v); check("R6 result of acquired conversion", v, raw(6, 0));

        // conversions 7 and 8: mode 1 restarts on the first cycle
        wr_cfg(4'b0001, 1);
        start_conv(); @(negedge clk); cnvst_n = 0;
        wait_eoc(n);
        @(negedge clk); cnvst_n = 1;
        @(posedge clk); #1;
        check("R7 auto acquisition restart", {15'd0, eoc_n}, 16'd1);
        wait_eoc(n);
        rd_one(v); check("R7 second result set", v, raw(8, 0));

        // conversion 9: read edge on the completion cycle
        wr_cfg(4'b0000, 1);
        start_conv();
        repeat (CC) @(posedge clk);
        @(negedge clk); cs_n = 0; rd_n = 0;
        @(posedge clk); #1;
        check("R8 completion wins over read", {15'd0, eoc_n}, 16'd0);
        check("R9 new ch0 on completion read", dq_o, raw(9, 0));
        @(negedge clk); cs_n = 1; rd_n = 1;
        rd_one(v); check("R9 next channel", v, raw(9, 1));
        check("R8 later read clears flag", {15'd0, eoc_n}, 16'd1);

        repeat (4) @(posedge clk);
        done_run = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule